// File: doc/BRIEF.md
# Timer Break Input Protection

This block protects the outputs of a PWM timer. It gathers fault ("break") sources and produces a main output enable, `moe`, that gates the timer's output stage. There are two break channels, and each has an input pin and a set of internal comparator inputs. Each channel has its own enable, its own polarity and its own glitch filter. A third path, for internal faults, takes several fault lines. It has no filter and no enable, and it is always active-high.

A detected break pulls `moe` low in the same cycle, without waiting for a clock edge. The held enable is then cleared at the next clock edge. It stays cleared until software sets it again, or until an update event arrives while automatic re-enable is switched on.

Software reaches the block through a small register port. It uses this port to set the channel configuration, to read and clear sticky break flags, to force a break on either channel, and to write the enable. When the enable is read back, the value comes through a two-stage resynchronizer, so it lags the real gating signal.

Top module: `timer_break_guard`

## Requirements
- R1: After reset, `moe` is 0, every configuration field reads 0, and the status register reads 0.
- R2: For each channel, the raw level is the OR of its pin and all of its comparator inputs. With polarity 1 (CTRL bit 1 for channel 1, bit 3 for channel 2), a raw level of 1 is a break. With polarity 0, a raw level of 0 is a break. When the channel's filter is 0, `moe` goes low in the same cycle the break appears.
- R3: When a channel's enable bit is 0 (CTRL bit 0 for channel 1, bit 2 for channel 2), its pin and comparator inputs have no effect on `moe` or on its flag.
- R4: The 4-bit filter field N (CTRL[11:8] for channel 1, CTRL[15:12] for channel 2) accepts a break only after the active level has been sampled on N consecutive clock edges and is still present. An active pulse shorter than that is ignored.
- R5: Writing 1 to FORCE (address 2) bit 0 or bit 1 breaks channel 1 or channel 2, whatever the enable bits hold. `moe` is 0 after that write's clock edge, and the channel's flag is set.
- R6: While any internal-fault line is high and automatic re-enable is off, `moe` is forced low in the same cycle. This path has no filter and no enable. It sets STATUS bit 2.
- R7: STATUS (address 1) holds sticky flags: bit 0 for channel 1, bit 1 for channel 2, bit 2 for internal fault. Writing 1 to a bit clears it, and writing 0 has no effect. A new break in the same cycle as a clear leaves the flag set.
- R8: A write to CTRL (address 0) of the enable, polarity, filter or auto-enable fields takes effect one clock after the write edge, and reads back the new value only from then on.
- R9: CTRL bit 5 written 1 sets the held enable and written 0 clears it. A break in the same cycle as the write wins. Once cleared by a break, `moe` stays 0 after the break goes away.
- R10: With CTRL bit 4 (automatic re-enable) set, a rising internal fault clears `moe` at the next edge, and a pulse on `updateEv` sets `moe` again even while the fault is still high. It does not do so while a filtered channel is breaking. With CTRL bit 4 clear, `updateEv` has no effect.
- R11: CTRL bit 5 reads the value `moe` had two clock edges earlier, through a two-stage resynchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 CTRL, 1 STATUS, 2 FORCE) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` |
| pinBrk1 | input | 1 | Channel 1 external break pin |
| pinBrk2 | input | 1 | Channel 2 external break pin |
| cmpBrk1 | input | NCMP1 | Channel 1 comparator break inputs |
| cmpBrk2 | input | NCMP2 | Channel 2 comparator break inputs |
| faultIn | input | NFAULT | Internal fault lines (clock failure, supply monitor, CPU lockup) |
| updateEv | input | 1 | Timer update event pulse |
| moe | output | 1 | Main output enable gating the timer outputs |

## Verification
A break can arrive in the same cycle as an attempt to raise the enable, either from a CTRL write of bit 5 or from an update event in automatic mode. The bench provokes this in three ways. It writes the enable while an internal fault is held high. It pulses `updateEv` while channel 1's pin is breaking in automatic mode. It also runs a random phase that issues enable writes while random pin and comparator patterns break both channels. In every case the break must win: `moe` reads 0 on the following cycle, and it rises only on a later write or update with no break present.

// File: rtl/brk_guard_pkg.sv
package brk_guard_pkg;
  localparam int FILT_W = 4;
  localparam int DATA_W = 16;
  localparam int CHANS  = 2;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_FORCE = 2'd2;

  typedef struct packed {
    logic              en;
    logic              pol;
    logic [FILT_W-1:0] filt;
  } chanCfg_t;

  typedef struct packed {
    chanCfg_t [CHANS-1:0] chan;
    logic                 autoEn;
  } brkCfg_t;

  // strobes from datapath to control
  typedef struct packed {
    logic [CHANS-1:0] chanHit;
    logic             faultAny;
    logic             faultRise;
  } brkHits_t;
endpackage

// File: rtl/brk_guard_dp.sv
module brk_guard_dp
  import brk_guard_pkg::*;
#(
  parameter int NCMP1  = 2,
  parameter int NCMP2  = 4,
  parameter int NFAULT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  brkCfg_t           cfg,
  input  logic              pinBrk1,
  input  logic              pinBrk2,
  input  logic [NCMP1-1:0]  cmpBrk1,
  input  logic [NCMP2-1:0]  cmpBrk2,
  input  logic [NFAULT-1:0] faultIn,
  output brkHits_t          hits
);
  logic [CHANS-1:0] rawOr;
  logic [CHANS-1:0] hitVec;
  logic             faultPrev;
  logic             faultNow;

  assign rawOr[0] = pinBrk1 | (|cmpBrk1);
  assign rawOr[1] = pinBrk2 | (|cmpBrk2);

  for (genvar g = 0; g < CHANS; g++) begin : g_chan
    logic              activeLvl;
    logic [FILT_W-1:0] runCnt;

    assign activeLvl = cfg.chan[g].en &
                       (cfg.chan[g].pol ? rawOr[g] : ~rawOr[g]);

    // consecutive active samples, saturating
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               runCnt <= '0;
      else if (!activeLvl)     runCnt <= '0;
      else if (runCnt != '1)   runCnt <= runCnt + 1'b1;
    end

    assign hitVec[g] = activeLvl && (runCnt >= cfg.chan[g].filt);
  end

  assign faultNow = |faultIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultPrev <= 1'b0;
    else       faultPrev <= faultNow;
  end

  assign hits.chanHit   = hitVec;
  assign hits.faultAny  = faultNow;
  assign hits.faultRise = faultNow & ~faultPrev;
endmodule

// File: rtl/brk_guard_ctrl.sv
module brk_guard_ctrl
  import brk_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              updateEv,
  input  brkHits_t          hits,
  output brkCfg_t           cfgEff,
  output logic              moe,
  output logic              moeHeld,
  output logic [2:0]        flagsOut
);
  brkCfg_t          cfgPend;
  brkCfg_t          cfgWr;
  logic             ctrlWr;
  logic             statWr;
  logic             forceWr;
  logic [CHANS-1:0] swBrk;
  logic             faultClr;
  logic             breakEvt;
  logic             combMask;
  logic             moeS1;
  logic             moeS2;
  logic [2:0]       flags;
  logic [2:0]       clrMask;
  logic [2:0]       setMask;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata[7:6];

  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign statWr  = regWe && (regAddr == ADDR_STAT);
  assign forceWr = regWe && (regAddr == ADDR_FORCE);

  always_comb begin
    cfgWr.chan[0].en   = regWdata[0];
    cfgWr.chan[0].pol  = regWdata[1];
    cfgWr.chan[1].en   = regWdata[2];
    cfgWr.chan[1].pol  = regWdata[3];
    cfgWr.autoEn       = regWdata[4];
    cfgWr.chan[0].filt = regWdata[11:8];
    cfgWr.chan[1].filt = regWdata[15:12];
  end

  // two-step staging: write edge -> pending, next edge -> effective
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPend <= '0;
      cfgEff  <= '0;
    end else begin
      if (ctrlWr) cfgPend <= cfgWr;
      cfgEff <= cfgPend;
    end
  end

  assign swBrk    = forceWr ? regWdata[CHANS-1:0] : '0;
  assign faultClr = cfgEff.autoEn ? hits.faultRise : hits.faultAny;
  assign breakEvt = (|hits.chanHit) | (|swBrk) | faultClr;
  assign combMask = (|hits.chanHit) | (hits.faultAny & ~cfgEff.autoEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            moeHeld <= 1'b0;
    else if (breakEvt)                    moeHeld <= 1'b0;
    else if (ctrlWr)                      moeHeld <= regWdata[5];
    else if (cfgEff.autoEn && updateEv)   moeHeld <= 1'b1;
  end

  assign moe = moeHeld & ~combMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moeS1 <= 1'b0;
      moeS2 <= 1'b0;
    end else begin
      moeS1 <= moe;
      moeS2 <= moeS1;
    end
  end

  assign clrMask = statWr ? regWdata[2:0] : 3'b000;
  assign setMask = {hits.faultAny, hits.chanHit | swBrk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | setMask;
  end

  assign flagsOut = flags;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = {cfgEff.chan[1].filt, cfgEff.chan[0].filt, 2'b00,
                             moeS2, cfgEff.autoEn,
                             cfgEff.chan[1].pol, cfgEff.chan[1].en,
                             cfgEff.chan[0].pol, cfgEff.chan[0].en};
      ADDR_STAT: regRdata = {{(DATA_W-3){1'b0}}, flags};
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_break_guard.sv
module timer_break_guard
  import brk_guard_pkg::*;
#(
  parameter int NCMP1  = 2,
  parameter int NCMP2  = 4,
  parameter int NFAULT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              pinBrk1,
  input  logic              pinBrk2,
  input  logic [NCMP1-1:0]  cmpBrk1,
  input  logic [NCMP2-1:0]  cmpBrk2,
  input  logic [NFAULT-1:0] faultIn,
  input  logic              updateEv,
  output logic              moe
);
  brkCfg_t    cfgEff;
  brkHits_t   hits;
  logic       moeHeld;
  logic [2:0] statFlags;

  brk_guard_dp #(.NCMP1(NCMP1), .NCMP2(NCMP2), .NFAULT(NFAULT)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfgEff),
    .pinBrk1(pinBrk1), .pinBrk2(pinBrk2),
    .cmpBrk1(cmpBrk1), .cmpBrk2(cmpBrk2),
    .faultIn(faultIn), .hits(hits)
  );

  brk_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .updateEv(updateEv), .hits(hits), .cfgEff(cfgEff),
    .moe(moe), .moeHeld(moeHeld), .flagsOut(statFlags)
  );
endmodule

// File: rtl/brk_guard_chk.sv
module brk_guard_chk
  import brk_guard_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              updateEv,
  input brkHits_t          hits,
  input brkCfg_t           cfgEff,
  input logic              moe,
  input logic              moeHeld,
  input logic [2:0]        statFlags
);
  logic swWr;
  logic ctrlWr;
  logic statClr0;

  assign swWr     = regWe && (regAddr == ADDR_FORCE) && (|regWdata[1:0]);
  assign ctrlWr   = regWe && (regAddr == ADDR_CTRL);
  assign statClr0 = regWe && (regAddr == ADDR_STAT) && regWdata[0];

  AST_CHAN_HIT_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (|hits.chanHit) |-> !moe); // R2

  AST_FAULT_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (hits.faultAny && !cfgEff.autoEn) |-> !moe); // R6

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((|hits.chanHit) || swWr) |=> !moe); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statFlags[0] && !statClr0) |=> statFlags[0]); // R7

  AST_AUTO_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEff.autoEn && updateEv && !(|hits.chanHit) && !swWr &&
     !hits.faultRise && !ctrlWr) |=> moeHeld); // R10

  AST_MOE_READ_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> (regRdata[5] == $past(moe, 2))); // R11
endmodule

bind timer_break_guard brk_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .updateEv(updateEv),
  .hits(hits), .cfgEff(cfgEff), .moe(moe), .moeHeld(moeHeld),
  .statFlags(statFlags)
);

// File: tb/test_timer_break_guard.sv
`timescale 1ns/100ps
module test_timer_break_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        pinBrk1 = 1'b0;
  logic        pinBrk2 = 1'b0;
  logic [1:0]  cmpBrk1 = 2'd0;
  logic [3:0]  cmpBrk2 = 4'd0;
  logic [2:0]  faultIn = 3'd0;
  logic        updateEv = 1'b0;
  logic        moe;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  timer_break_guard i_timer_break_guard (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .pinBrk1(pinBrk1), .pinBrk2(pinBrk2), .cmpBrk1(cmpBrk1), .cmpBrk2(cmpBrk2),
    .faultIn(faultIn), .updateEv(updateEv), .moe(moe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #0.2;
    d = regRdata;
  endtask

  task automatic chkMoe(input string req, input logic exp);
    #0.2;
    chk(req, {15'd0, moe}, {15'd0, exp});
  endtask

  // requirement model: break on a channel
  function automatic bit expHit(bit pin, logic [3:0] cmp, bit en, bit pol);
    bit raw;
    raw = pin | (|cmp);
    return en & (pol ? raw : ~raw);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    bit mReg;
    void'($urandom(32'd4711));
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    rd(2'd0, rv); chk("R1 ctrl", rv, 16'h0000);
    rd(2'd1, rv); chk("R1 stat", rv, 16'h0000);
    chkMoe("R1 moe", 1'b0);

    // R8 staging, R9 set, R11 read lag
    wr(2'd0, 16'h0023);
    rd(2'd0, rv); chk("R8 old cfg", rv, 16'h0000);
    chkMoe("R9 set", 1'b1);
    tick(); rd(2'd0, rv); chk("R8 new cfg", rv, 16'h0003);
    tick(); rd(2'd0, rv); chk("R11 moe read", rv, 16'h0023);

    // R2 pin break, unfiltered
    tick(); pinBrk1 = 1'b1; chkMoe("R2 pin break", 1'b0);
    tick(); pinBrk1 = 1'b0; chkMoe("R9 stays low", 1'b0);
    rd(2'd1, rv); chk("R7 flag1", rv, 16'h0001);
    wr(2'd1, 16'h0001); rd(2'd1, rv); chk("R7 clear", rv, 16'h0000);

    // R2 low polarity and OR of sources
    pinBrk1 = 1'b1;
    wr(2'd0, 16'h0020);
    wr(2'd0, 16'h0021);
    tick(); chkMoe("R2 pol0 high raw", 1'b1);
    pinBrk1 = 1'b0; cmpBrk1 = 2'b10; chkMoe("R2 OR comparator", 1'b1);
    cmpBrk1 = 2'b00; chkMoe("R2 pol0 break", 1'b0);

    // R3 disabled channel
    tick(); pinBrk1 = 1'b1;
    wr(2'd0, 16'h0022);
    tick(); wr(2'd1, 16'h0007);
    cmpBrk1 = 2'b11;
    repeat (3) tick();
    chkMoe("R3 disabled", 1'b1);
    rd(2'd1, rv); chk("R3 no flag", rv, 16'h0000);

    // R4 filter of 3 samples
    pinBrk1 = 1'b0; cmpBrk1 = 2'b00;
    wr(2'd0, 16'h0323);
    tick(); chkMoe("R4 armed", 1'b1);
    pinBrk1 = 1'b1; chkMoe("R4 not immediate", 1'b1);
    tick(); tick(); chkMoe("R4 two samples", 1'b1);
    pinBrk1 = 1'b0;
    tick(); tick(); chkMoe("R4 short pulse", 1'b1);
    rd(2'd1, rv); chk("R4 no flag", rv, 16'h0000);
    pinBrk1 = 1'b1;
    tick(); tick(); chkMoe("R4 two of three", 1'b1);
    tick(); chkMoe("R4 accepted", 1'b0);
    pinBrk1 = 1'b0;
    wr(2'd1, 16'h0007);

    // R5 software break ignores enable
    wr(2'd0, 16'h0020);
    tick(); chkMoe("R5 armed", 1'b1);
    wr(2'd2, 16'h0002); chkMoe("R5 sw break", 1'b0);
    rd(2'd1, rv); chk("R5 flag2", rv, 16'h0002);

    // R6 internal fault
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h0020);
    tick(); chkMoe("R6 armed", 1'b1);
    faultIn = 3'b100; chkMoe("R6 fault immediate", 1'b0);
    tick(); faultIn = 3'b000; chkMoe("R9 latched low", 1'b0);
    rd(2'd1, rv); chk("R6 fault flag", rv, 16'h0004);

    // R7 set wins over clear, write 0 no effect
    faultIn = 3'b001; tick();
    wr(2'd1, 16'h0004); rd(2'd1, rv); chk("R7 set wins", rv, 16'h0004);
    faultIn = 3'b000;
    wr(2'd1, 16'h0000); rd(2'd1, rv); chk("R7 zero write", rv, 16'h0004);
    wr(2'd1, 16'h0004); rd(2'd1, rv); chk("R7 w1c", rv, 16'h0000);

    // R9 break beats set; clear by write
    faultIn = 3'b010;
    wr(2'd0, 16'h0020);
    faultIn = 3'b000; chkMoe("R9 break beats set", 1'b0);
    wr(2'd0, 16'h0020); chkMoe("R9 set again", 1'b1);
    wr(2'd0, 16'h0000); chkMoe("R9 clear", 1'b0);
    updateEv = 1'b1; tick(); updateEv = 1'b0;
    chkMoe("R10 update ignored without auto", 1'b0);

    // R10 automatic re-enable
    wr(2'd0, 16'h0030);
    tick(); chkMoe("R10 armed", 1'b1);
    faultIn = 3'b001; chkMoe("R10 level not gating", 1'b1);
    tick(); chkMoe("R10 rise clears", 1'b0);
    updateEv = 1'b1; tick(); updateEv = 1'b0;
    chkMoe("R10 restore with fault", 1'b1);
    tick(); chkMoe("R10 fault held", 1'b1);
    faultIn = 3'b000;
    wr(2'd0, 16'h0033);
    tick(); pinBrk1 = 1'b1; chkMoe("R10 pin break", 1'b0);
    updateEv = 1'b1; tick(); updateEv = 1'b0; pinBrk1 = 1'b0;
    chkMoe("R10 break beats update", 1'b0);
    updateEv = 1'b1; tick(); updateEv = 1'b0;
    chkMoe("R10 restore", 1'b1);

    // random phase: ch1 active-high, ch2 active-low, both unfiltered
    pinBrk2 = 1'b1;
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h0027);
    tick(); tick(); chkMoe("R2 random armed", 1'b1);
    mReg = 1'b1;
    for (int i = 0; i < 400; i++) begin
      bit doSet;
      bit hitNow;
      @(negedge clk);
      pinBrk1 = ($urandom % 8) == 0;
      cmpBrk1 = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
      pinBrk2 = ($urandom % 6) != 0;
      cmpBrk2 = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0000;
      doSet = !mReg && (($urandom % 3) == 0);
      regWe = doSet; regAddr = 2'd0; regWdata = doSet ? 16'h0027 : 16'h0000;
      hitNow = expHit(pinBrk1, {2'b00, cmpBrk1}, 1'b1, 1'b1) |
               expHit(pinBrk2, cmpBrk2, 1'b1, 1'b0);
      chkMoe("R2 random gating", mReg & ~hitNow);
      @(posedge clk);
      mReg = hitNow ? 1'b0 : (doSet ? 1'b1 : mReg);
    end
    @(negedge clk);
    regWe = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule